// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer whose countdown runs entirely on its own low-speed clock. Software on the bus clock side starts it and then keeps it alive by writing a refresh key to a key register before the 12-bit down counter runs out. If the counter is allowed to reach zero, the block raises a one-slow-cycle reset request and reloads itself. Because the counting logic sees only the slow clock, it keeps working while the bus clock is stopped in low-power states. A strap input lets the watchdog come out of reset already counting from the maximum value, without any software start.

The timeout is set by two configuration registers: a prescaler code, which selects a slow-clock divisor from 4 to 256 in powers of two, and a 12-bit reload value. Both registers are guarded by a key sequence. Writing the unlock key opens them; writing any other key value closes them again. An accepted write is handed to the slow domain through a toggle-and-acknowledge crossing. A per-register busy flag in the status register shows that the transfer is still under way, and further writes to that register are dropped until the flag clears.

There are two state machines. The bus-side key machine has the states KEY_LOCKED and KEY_OPEN. It moves from KEY_LOCKED to KEY_OPEN when the unlock key is written, and from KEY_OPEN back to KEY_LOCKED on a key write of any other value. The slow-side core machine has the states CORE_IDLE and CORE_COUNTING. It moves from CORE_IDLE to CORE_COUNTING on a start command, or it resets directly into CORE_COUNTING when the strap is high. It never leaves CORE_COUNTING except through the slow-domain reset.

Top module: `keyed_watchdog`

## Requirements
- R1: Writes to the prescaler (address 1) and reload (address 2) registers take effect only while the key machine is open. Key value 0x5555 written to address 0 opens it. Any other value written to address 0 closes it, and a write to address 1 or 2 while it is closed leaves the register unchanged.
- R2: Register map: address 0 is the key register and reads 0. Address 1 holds the prescaler code in bits [2:0]. Address 2 holds the reload value in bits [11:0]. Address 3 is status, with bit 0 the prescaler busy flag and bit 1 the reload busy flag. After reset these read 0, 0x000, 0xFFF and 0.
- R3: An accepted configuration write sets its busy flag, which reads 1 on the next bus cycle and clears within 6 slow-clock periods. A write to that register while its flag is set is ignored.
- R4: Key value 0xCCCC starts counting. With the strap low and no start, reset_req stays low.
- R5: While counting, consecutive reset requests are (R+1)*D slow cycles apart, where R is the reload value and D = 4 << min(code, 6). Codes 6 and 7 both give 256.
- R6: reset_req is high for exactly one slow-clock cycle per expiry.
- R7: Key value 0xAAAA reloads the counter and restarts the divider. A refresh repeated faster than the period prevents any request, and after the last refresh the next request follows (R+1)*D slow cycles after the command is taken up.
- R8: Once counting, no key value stops the watchdog.
- R9: With the strap high at slow-domain reset, the block counts from 0xFFF at divide-by-4, and the first request comes 16384 slow cycles after reset release.
- R10: Counting and requests go on unchanged while the bus clock is stopped.
- R11: A reload value of 0 gives a request every D slow cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-side register clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| slow_clk | input | 1 | Low-speed counting clock |
| slow_rst_n | input | 1 | Active-low asynchronous reset, slow domain |
| auto_start_strap | input | 1 | Starts counting at slow-domain reset when high |
| reset_req | output | 1 | One-slow-cycle system reset request |

## Verification
The bench sweeps prescaler codes 0, 1, 2 and the saturated code 7 against reload values 0, 2 and 5, and measures the exact slow-cycle spacing between requests. A divisor or terminal-count error of one shows up as a wrong interval, and an unsaturated code 7 shows up as a doubled one. It attempts writes while locked, after a non-unlock key and during a pending transfer. A design that let any of these through would show a changed read-back value. Refresh is driven just faster than the period, which catches a refresh that fails to restart the divider. The bus clock is gated off during a measurement, which catches any dependence of the countdown on bus-side logic. A strap reset is timed to its first request, which catches a wrong reset count or a missing automatic start.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;
    localparam int          KEY_W       = 16;
    localparam logic [15:0] KEY_START   = 16'hCCCC;
    localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [15:0] KEY_UNLOCK  = 16'h5555;

    typedef enum logic [1:0] {
        ADDR_KEY    = 2'd0,
        ADDR_PRESC  = 2'd1,
        ADDR_RELOAD = 2'd2,
        ADDR_STATUS = 2'd3
    } reg_addr_e;

    typedef enum logic {
        KEY_LOCKED,
        KEY_OPEN
    } key_state_e;

    typedef enum logic {
        CORE_IDLE,
        CORE_COUNTING
    } core_state_e;

    localparam int CMD_START   = 0;
    localparam int CMD_REFRESH = 1;
    localparam int CMD_N       = 2;
endpackage

// File: rtl/wdg_sync2.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a single level signal.
module wdg_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/wdg_key_ctrl.sv
`timescale 1ns/1ps
// Bus-side key decoder: lock state machine and command toggles.
module wdg_key_ctrl
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [KEY_W-1:0] wdata,
    output logic             unlocked,
    output logic [CMD_N-1:0] cmd_tgl
);
    key_state_e       state_q, state_d;
    logic             key_wr;
    logic [CMD_N-1:0] tgl_q;

    assign key_wr = wr_en && (reg_addr_e'(addr) == ADDR_KEY);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_LOCKED;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_LOCKED: if (key_wr && wdata == KEY_UNLOCK) state_d = KEY_OPEN;
            KEY_OPEN:   if (key_wr && wdata != KEY_UNLOCK) state_d = KEY_LOCKED;
        endcase
    end

    // outputs: command toggles flip once per recognised command key
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_q <= '0;
        end else if (key_wr) begin
            if (wdata == KEY_START)   tgl_q[CMD_START]   <= ~tgl_q[CMD_START];
            if (wdata == KEY_REFRESH) tgl_q[CMD_REFRESH] <= ~tgl_q[CMD_REFRESH];
        end
    end

    assign unlocked = (state_q == KEY_OPEN);
    assign cmd_tgl  = tgl_q;

    p_relock_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wdata != KEY_UNLOCK) |=> !unlocked)
        else $error("R1: key write other than unlock left registers open");

    p_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wdata == KEY_UNLOCK) |=> unlocked)
        else $error("R1: unlock key did not open registers");
endmodule

// File: rtl/wdg_cfg_xfer.sv
`timescale 1ns/1ps
// One configuration register: bus-side shadow, busy flag and
// toggle/acknowledge handover into the slow domain.
module wdg_cfg_xfer #(
    parameter int            W       = 12,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         bus_clk,
    input  logic         bus_rst_n,
    input  logic         wr_req,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] shadow,
    output logic         busy,
    input  logic         slow_clk,
    input  logic         slow_rst_n,
    output logic [W-1:0] active
);
    logic [W-1:0] shadow_q;
    logic         busy_q;
    logic         req_tgl_q;
    logic         ack_bus;
    logic         req_slow;
    logic         seen_q;
    logic [W-1:0] active_q;

    // bus side
    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            shadow_q  <= RST_VAL;
            busy_q    <= 1'b0;
            req_tgl_q <= 1'b0;
        end else if (wr_req && !busy_q) begin
            shadow_q  <= wr_data;
            busy_q    <= 1'b1;
            req_tgl_q <= ~req_tgl_q;
        end else if (busy_q && (ack_bus == req_tgl_q)) begin
            busy_q    <= 1'b0;
        end
    end

    wdg_sync2 u_req_sync (
        .clk   (slow_clk),
        .rst_n (slow_rst_n),
        .d     (req_tgl_q),
        .q     (req_slow)
    );

    // slow side: shadow is held still while busy, so it is safe to sample here
    always_ff @(posedge slow_clk or negedge slow_rst_n) begin
        if (!slow_rst_n) begin
            seen_q   <= 1'b0;
            active_q <= RST_VAL;
        end else if (req_slow != seen_q) begin
            seen_q   <= req_slow;
            active_q <= shadow_q;
        end
    end

    wdg_sync2 u_ack_sync (
        .clk   (bus_clk),
        .rst_n (bus_rst_n),
        .d     (seen_q),
        .q     (ack_bus)
    );

    assign shadow = shadow_q;
    assign busy   = busy_q;
    assign active = active_q;

    p_busy_set_r3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (wr_req && !busy_q) |=> busy_q)
        else $error("R3: accepted write did not raise busy");

    p_hold_busy_r3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (wr_req && busy_q) |=> $stable(shadow_q))
        else $error("R3: write during busy changed the register");
endmodule

// File: rtl/wdg_slow_core.sv
`timescale 1ns/1ps
// Slow-domain counting core: run state machine, divider and down counter.
module wdg_slow_core
    import kwd_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int PR_W        = 3,
    parameter int PR_MAX_CODE = 6,
    parameter int DIV_MIN_LOG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_start,
    input  logic [CMD_N-1:0] cmd_sync,
    input  logic [PR_W-1:0]  presc_code,
    input  logic [CNT_W-1:0] reload_val,
    output logic             reset_req
);
    localparam int DIV_W = DIV_MIN_LOG + PR_MAX_CODE;

    core_state_e      state_q, state_d;
    logic [CMD_N-1:0] prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_lim;
    logic             req_q;
    logic             start_evt;
    logic             refresh_evt;
    logic             tick;

    function automatic logic [DIV_W-1:0] limit_of(input logic [PR_W-1:0] code);
        int lg;
        lg = DIV_MIN_LOG + ((int'(code) > PR_MAX_CODE) ? PR_MAX_CODE : int'(code));
        return DIV_W'((1 << lg) - 1);
    endfunction

    assign start_evt   = cmd_sync[CMD_START]   ^ prev_q[CMD_START];
    assign refresh_evt = cmd_sync[CMD_REFRESH] ^ prev_q[CMD_REFRESH];
    assign div_lim     = limit_of(presc_code);
    assign tick        = (div_q >= div_lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cmd_sync;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= auto_start ? CORE_COUNTING : CORE_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CORE_IDLE:     if (start_evt) state_d = CORE_COUNTING;
            CORE_COUNTING: state_d = CORE_COUNTING;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '1;
            div_q <= '0;
            req_q <= 1'b0;
        end else begin
            req_q <= 1'b0;
            unique case (state_q)
                CORE_IDLE: begin
                    if (start_evt) begin
                        cnt_q <= reload_val;
                        div_q <= '0;
                    end
                end
                CORE_COUNTING: begin
                    if (refresh_evt) begin
                        cnt_q <= reload_val;
                        div_q <= '0;
                    end else if (tick) begin
                        div_q <= '0;
                        if (cnt_q == '0) begin
                            cnt_q <= reload_val;
                            req_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end else begin
                        div_q <= div_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign reset_req = req_q;

    p_pulse_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q)
        else $error("R6: reset request longer than one cycle");

    p_no_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CORE_COUNTING) |=> (state_q == CORE_COUNTING))
        else $error("R8: watchdog left counting state");

    p_req_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> ($past(cnt_q) == '0))
        else $error("R5: request raised with counter not at zero");

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CORE_IDLE) |-> !req_q)
        else $error("R4: request while not started");
endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
// Top: key-protected watchdog with separate slow counting domain.
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int PR_W        = 3,
    parameter int PR_MAX_CODE = 6,
    parameter int DIV_MIN_LOG = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [KEY_W-1:0] bus_wdata,
    output logic [KEY_W-1:0] bus_rdata,
    input  logic             slow_clk,
    input  logic             slow_rst_n,
    input  logic             auto_start_strap,
    output logic             reset_req
);
    logic             unlocked;
    logic [CMD_N-1:0] cmd_tgl;
    logic [CMD_N-1:0] cmd_sync;
    logic             pr_we, rl_we;
    logic [PR_W-1:0]  pr_shadow, pr_active;
    logic [CNT_W-1:0] rl_shadow, rl_active;
    logic             pr_busy, rl_busy;
    reg_addr_e        addr_e;

    assign addr_e = reg_addr_e'(bus_addr);
    assign pr_we  = bus_wr && unlocked && (addr_e == ADDR_PRESC);
    assign rl_we  = bus_wr && unlocked && (addr_e == ADDR_RELOAD);

    wdg_key_ctrl u_key (
        .clk      (bus_clk),
        .rst_n    (bus_rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .unlocked (unlocked),
        .cmd_tgl  (cmd_tgl)
    );

    wdg_cfg_xfer #(.W(PR_W), .RST_VAL('0)) u_presc (
        .bus_clk    (bus_clk),
        .bus_rst_n  (bus_rst_n),
        .wr_req     (pr_we),
        .wr_data    (bus_wdata[PR_W-1:0]),
        .shadow     (pr_shadow),
        .busy       (pr_busy),
        .slow_clk   (slow_clk),
        .slow_rst_n (slow_rst_n),
        .active     (pr_active)
    );

    wdg_cfg_xfer #(.W(CNT_W), .RST_VAL('1)) u_reload (
        .bus_clk    (bus_clk),
        .bus_rst_n  (bus_rst_n),
        .wr_req     (rl_we),
        .wr_data    (bus_wdata[CNT_W-1:0]),
        .shadow     (rl_shadow),
        .busy       (rl_busy),
        .slow_clk   (slow_clk),
        .slow_rst_n (slow_rst_n),
        .active     (rl_active)
    );

    for (genvar g = 0; g < CMD_N; g++) begin : g_cmd_sync
        wdg_sync2 u_cmd (
            .clk   (slow_clk),
            .rst_n (slow_rst_n),
            .d     (cmd_tgl[g]),
            .q     (cmd_sync[g])
        );
    end

    wdg_slow_core #(
        .CNT_W       (CNT_W),
        .PR_W        (PR_W),
        .PR_MAX_CODE (PR_MAX_CODE),
        .DIV_MIN_LOG (DIV_MIN_LOG)
    ) u_core (
        .clk        (slow_clk),
        .rst_n      (slow_rst_n),
        .auto_start (auto_start_strap),
        .cmd_sync   (cmd_sync),
        .presc_code (pr_active),
        .reload_val (rl_active),
        .reset_req  (reset_req)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (addr_e)
            ADDR_KEY:    bus_rdata = '0;
            ADDR_PRESC:  bus_rdata[PR_W-1:0]  = pr_shadow;
            ADDR_RELOAD: bus_rdata[CNT_W-1:0] = rl_shadow;
            ADDR_STATUS: bus_rdata[1:0]       = {rl_busy, pr_busy};
        endcase
    end

    p_locked_presc_r1: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (bus_wr && !unlocked && addr_e == ADDR_PRESC) |=> $stable(pr_shadow))
        else $error("R1: prescaler written while locked");

    p_locked_reload_r1: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (bus_wr && !unlocked && addr_e == ADDR_RELOAD) |=> $stable(rl_shadow))
        else $error("R1: reload written while locked");
endmodule

// File: tb/keyed_watchdog_tb_top.sv
`timescale 1ns/1ps
module keyed_watchdog_tb_top;
    logic        braw = 1'b0;
    logic        bclk_on = 1'b1;
    logic        sclk = 1'b0;
    logic        bus_clk;
    logic        bus_rst_n = 1'b0;
    logic        slow_rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        strap = 1'b0;
    logic        reset_req;

    int nvec = 0;
    int nbad = 0;
    int unsigned scnt = 0, pcnt = 0, last_p = 0, prev_p = 0;

    always #2.5 braw = ~braw;      // 200 MHz bus clock
    always #10  sclk = ~sclk;      // 50 MHz slow clock
    assign bus_clk = braw & bclk_on;

    keyed_watchdog dut_i (
        .bus_clk          (bus_clk),
        .bus_rst_n        (bus_rst_n),
        .bus_wr           (bus_wr),
        .bus_addr         (bus_addr),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .slow_clk         (sclk),
        .slow_rst_n       (slow_rst_n),
        .auto_start_strap (strap),
        .reset_req        (reset_req)
    );

    always @(negedge sclk) begin
        scnt = scnt + 1;
        if (reset_req === 1'b1) begin
            prev_p = last_p;
            last_p = scnt;
            pcnt   = pcnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [1:0] a, input logic [15:0] d);
        @(negedge bus_clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge bus_clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [1:0] a, output int v);
        @(negedge bus_clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic wait_idle(input string req, input int limit);
        int v;
        int n = 0;
        bread(2'd3, v);
        while (v != 0 && n < 60) begin
            bread(2'd3, v);
            n++;
        end
        chk(n <= limit, req, n, limit);
    endtask

    task automatic wait_pulse(output bit ok, input int limit);
        int unsigned p0 = pcnt;
        int k = 0;
        while (pcnt == p0 && k < limit) begin
            @(posedge sclk);
            k++;
        end
        ok = (pcnt != p0);
    endtask

    task automatic measure(input int exp, input string req);
        bit ok1, ok2;
        wait_pulse(ok1, exp + 40000);
        wait_pulse(ok2, exp + 100);
        chk(ok1 && ok2 && (last_p - prev_p) == exp, req, int'(last_p - prev_p), exp);
    endtask

    task automatic set_cfg(input int code, input int rl);
        bwrite(2'd0, 16'h5555);
        bwrite(2'd1, 16'(code));
        wait_idle("R3 busy clear", 24);
        bwrite(2'd2, 16'(rl));
        wait_idle("R3 busy clear", 24);
    endtask

    initial begin
        #900000;
        nbad++;
        $display("FAIL watchdog timeout actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        int v;
        int unsigned p0, s0;
        bit ok;
        repeat (4) @(negedge sclk);
        bus_rst_n = 1'b1;
        slow_rst_n = 1'b1;

        // R2 reset values
        bread(2'd0, v); chk(v == 0, "R2 key reads 0", v, 0);
        bread(2'd1, v); chk(v == 0, "R2 prescaler reset", v, 0);
        bread(2'd2, v); chk(v == 16'hFFF, "R2 reload reset", v, 16'hFFF);
        bread(2'd3, v); chk(v == 0, "R2 status reset", v, 0);
        // R4 nothing without start
        p0 = pcnt;
        repeat (500) @(posedge sclk);
        chk(pcnt == p0, "R4 no request before start", int'(pcnt - p0), 0);

        // R1 locked write ignored
        bwrite(2'd1, 16'd3);
        bread(2'd1, v); chk(v == 0, "R1 locked prescaler write", v, 0);
        bwrite(2'd2, 16'd9);
        bread(2'd2, v); chk(v == 16'hFFF, "R1 locked reload write", v, 16'hFFF);

        // R3 busy and write during busy
        bwrite(2'd0, 16'h5555);
        bwrite(2'd1, 16'd1);
        bread(2'd3, v); chk(v == 1, "R3 prescaler busy set", v, 1);
        bwrite(2'd1, 16'd2);
        wait_idle("R3 busy clears in time", 24);
        bread(2'd1, v); chk(v == 1, "R3 write during busy ignored", v, 1);
        bwrite(2'd2, 16'd6);
        bread(2'd3, v); chk(v == 2, "R3 reload busy set", v, 2);
        wait_idle("R3 busy clears in time", 24);
        bread(2'd2, v); chk(v == 6, "R1 unlocked reload write", v, 6);

        // R1 other key relocks
        bwrite(2'd0, 16'h1234);
        bwrite(2'd2, 16'd5);
        bread(2'd2, v); chk(v == 6, "R1 relock by other key", v, 6);

        // R4 start, R5 period
        set_cfg(0, 3);
        bwrite(2'd0, 16'hCCCC);
        measure(16, "R4 R5 start and period");

        // R5 / R11 sweep
        for (int ci = 0; ci < 4; ci++) begin
            for (int ri = 0; ri < 3; ri++) begin
                int code = (ci == 3) ? 7 : ci;
                int rl = (ri == 0) ? 0 : (ri == 1) ? 2 : 5;
                int d = 4 << ((code > 6) ? 6 : code);
                set_cfg(code, rl);
                measure((rl + 1) * d, (rl == 0) ? "R11 zero reload" : "R5 period sweep");
            end
        end

        // R7 refresh
        set_cfg(0, 7);
        bwrite(2'd0, 16'hAAAA);
        repeat (20) @(negedge bus_clk);
        p0 = pcnt;
        for (int i = 0; i < 40; i++) begin
            bwrite(2'd0, 16'hAAAA);
            repeat (58) @(negedge bus_clk);
        end
        chk(pcnt == p0, "R7 refresh holds off request", int'(pcnt - p0), 0);
        bwrite(2'd0, 16'hAAAA);
        s0 = scnt;
        wait_pulse(ok, 200);
        chk(ok && (last_p - s0) >= 33 && (last_p - s0) <= 37,
            "R7 request after last refresh", int'(last_p - s0), 35);

        // R8 no stop
        bwrite(2'd0, 16'h0000);
        bwrite(2'd0, 16'hFFFF);
        bwrite(2'd0, 16'h5555);
        bwrite(2'd0, 16'hCCCC);
        measure(32, "R8 keeps running");

        // R6 pulse width: one negedge sample per pulse; check high exactly one slow cycle
        wait_pulse(ok, 200);
        @(posedge sclk); #1;
        chk(reset_req == 1'b0, "R6 single-cycle request", int'(reset_req), 0);

        // R10 bus clock stopped
        @(negedge braw); bclk_on = 1'b0;
        measure(32, "R10 count with bus clock off");
        @(negedge braw); bclk_on = 1'b1;

        // R9 strap start
        bus_rst_n = 1'b0;
        slow_rst_n = 1'b0;
        strap = 1'b1;
        repeat (4) @(negedge sclk);
        bus_rst_n = 1'b1;
        @(negedge sclk); #1;
        slow_rst_n = 1'b1;
        s0 = scnt;
        bread(2'd2, v); chk(v == 16'hFFF, "R9 reload after strap reset", v, 16'hFFF);
        wait_pulse(ok, 17000);
        chk(ok && (last_p - s0) >= 16384 && (last_p - s0) <= 16385,
            "R9 strap first request", int'(last_p - s0), 16384);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule